// File: doc/BRIEF.md
# Block Address Translation Array Pair

This block holds two independent, fully associative sets of block translation registers: one serves instruction fetches and the other serves data accesses. Each set has four entries by default. An entry maps a naturally aligned region of effective address space onto a physical region of the same size. The region size runs from 128 KB up to 256 MB in powers of two and comes from a per-entry length mask. An entry is usable only in the privilege modes it enables. Its supervisor-enable and user-enable bits are tested against the privilege flag that comes with each lookup.

A lookup request carries an effective address and a privilege flag. It enters one side on a valid/ready handshake and is compared against every entry of that side at once. One cycle later the side presents a registered result on a second valid/ready handshake. The result holds the hit flag, the translated physical address, the index of the winning entry, and that entry's attribute and protection fields. A hit here is meant to take precedence over any page translation path that runs beside the block.

System software maintains the entries through a single shared write port, which names a side and an entry index. Hardware never loads an entry itself. A request is accepted whenever the side's result register is empty or is being drained in the same cycle. A result that has not been taken stays unchanged, and while it waits, new requests on that side are held off.

Top module: `bat_xlate_unit`

## Requirements
- R1: After reset, both sides show no result (`rs_valid` low) and every entry is disabled, so any lookup returns a miss.
- R2: An entry matches when its mode enable for the request privilege (`lk_user`=1 selects the user bit, 0 the supervisor bit) is set, and effective address bits [31:17] equal `vbase` on every bit except bits 17+k for which `len_mask[k]`=1. Mask 0 therefore gives a 128 KB block and all-ones gives a 256 MB block.
- R3: On a hit, physical address bits [16:0] are the effective address bits. Each bit 17+k is taken from the effective address where `len_mask[k]`=1 and from `pbase` otherwise. Bits [31:28] always come from `pbase`. The winning entry's `attr` and `prot` are returned with it.
- R4: An entry with only its supervisor bit set misses for user requests, and an entry with only its user bit set misses for supervisor requests.
- R5: When several entries match, the entry with the lowest index wins, and `rs_idx` reports that index.
- R6: A write with `wr_side`=0 changes only the instruction side (side 0), and `wr_side`=1 changes only the data side (side 1).
- R7: `lk_ready` equals (not `rs_valid`) or `rs_ready`. A request accepted at a clock edge has its result on `rs_valid` right after that edge.
- R8: While `rs_valid` is high and `rs_ready` is low, every result output of that side holds its value.
- R9: A lookup accepted at the same edge as an entry write is resolved against the entry contents from before the write.
- R10: On a miss, `rs_pa`, `rs_idx`, `rs_attr` and `rs_prot` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_side | input | 1 | Written array: 0 instruction, 1 data |
| wr_idx | input | 2 | Written entry index |
| wr_vbase | input | 15 | Effective block base, address bits [31:17] |
| wr_len_mask | input | 11 | Length mask, bit k frees address bit 17+k |
| wr_sup_ok | input | 1 | Entry usable in supervisor mode |
| wr_usr_ok | input | 1 | Entry usable in user mode |
| wr_pbase | input | 15 | Physical block base, address bits [31:17] |
| wr_attr | input | 4 | Storage attribute field |
| wr_prot | input | 2 | Protection field |
| lk_valid | input | 2 | Lookup request valid, one bit per side |
| lk_ready | output | 2 | Lookup request ready, one bit per side |
| lk_ea | input | 2x32 | Effective address per side |
| lk_user | input | 2 | Request is user mode, per side |
| rs_valid | output | 2 | Result valid per side |
| rs_ready | input | 2 | Result ready per side |
| rs_hit | output | 2 | Block translation hit per side |
| rs_pa | output | 2x32 | Physical address per side |
| rs_idx | output | 2x2 | Winning entry index per side |
| rs_attr | output | 2x4 | Winning attribute field per side |
| rs_prot | output | 2x2 | Winning protection field per side |

## Verification
The bench probes both edges of a 128 KB block and a 256 MB block. A design that compared the wrong set of address bits would hit one block too early or miss inside one. Overlapping entries are set up so that two enabled entries hit the same address, and any priority other than lowest index returns the wrong physical base. A write to one side is followed by lookups on the other side, and a write lands in the same cycle as a lookup, which exposes a shared array or write-through forwarding. A stalled result is held while a second request waits, so a register that reloaded under back-pressure would visibly change its outputs.

// File: rtl/bat_xl_pkg.sv
package bat_xl_pkg;
  localparam int AW       = 32;
  localparam int LOW_BITS = 17;
  localparam int MASK_W   = 11;
  localparam int ATTR_W   = 4;
  localparam int PROT_W   = 2;
  localparam int BASE_W   = AW - LOW_BITS;
  localparam int FIX_W    = BASE_W - MASK_W;

  typedef struct packed {
    logic [BASE_W-1:0] vbase;
    logic [MASK_W-1:0] len_mask;
    logic              sup_ok;
    logic              usr_ok;
    logic [BASE_W-1:0] pbase;
    logic [ATTR_W-1:0] attr;
    logic [PROT_W-1:0] prot;
  } bat_ent_t;
endpackage

// File: rtl/bat_entry.sv
module bat_entry
  import bat_xl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  bat_ent_t          wdata,
  input  logic [AW-1:0]     ea,
  input  logic              user,
  output logic              hit,
  output logic [BASE_W-1:0] pa_hi,
  output logic [ATTR_W-1:0] attr,
  output logic [PROT_W-1:0] prot
);
  bat_ent_t          ent;
  logic [BASE_W-1:0] keep;
  logic [BASE_W-1:0] ea_hi;
  logic              mode_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent <= '0;
    else if (we) ent <= wdata;
  end

  // keep = 1 where the address bit is compared and replaced by the physical base
  assign keep    = {{FIX_W{1'b1}}, ~ent.len_mask};
  assign ea_hi   = ea[AW-1:LOW_BITS];
  assign mode_ok = user ? ent.usr_ok : ent.sup_ok;
  assign hit     = mode_ok && (((ea_hi ^ ent.vbase) & keep) == '0);
  assign pa_hi   = (ent.pbase & keep) | (ea_hi & ~keep);
  assign attr    = ent.attr;
  assign prot    = ent.prot;
endmodule

// File: rtl/bat_pick.sv
module bat_pick
  import bat_xl_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0]             hit_vec,
  input  logic [N_ENT-1:0][BASE_W-1:0] pa_vec,
  input  logic [N_ENT-1:0][ATTR_W-1:0] attr_vec,
  input  logic [N_ENT-1:0][PROT_W-1:0] prot_vec,
  output logic                         any_hit,
  output logic [IDX_W-1:0]             win_idx,
  output logic [BASE_W-1:0]            win_pa,
  output logic [ATTR_W-1:0]            win_attr,
  output logic [PROT_W-1:0]            win_prot
);
  // Scan from the top down so the lowest matching index is the last to write
  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    win_pa   = '0;
    win_attr = '0;
    win_prot = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit  = 1'b1;
        win_idx  = IDX_W'(i);
        win_pa   = pa_vec[i];
        win_attr = attr_vec[i];
        win_prot = prot_vec[i];
      end
    end
  end
endmodule

// File: rtl/bat_side.sv
module bat_side
  import bat_xl_pkg::*;
#(
  parameter int N_ENT = 4,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ENT-1:0]  we_vec,
  input  bat_ent_t          wdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [AW-1:0]     lk_ea,
  input  logic              lk_user,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [AW-1:0]     rs_pa,
  output logic [IDX_W-1:0]  rs_idx,
  output logic [ATTR_W-1:0] rs_attr,
  output logic [PROT_W-1:0] rs_prot
);
  logic [N_ENT-1:0]             hit_vec;
  logic [N_ENT-1:0][BASE_W-1:0] pa_vec;
  logic [N_ENT-1:0][ATTR_W-1:0] attr_vec;
  logic [N_ENT-1:0][PROT_W-1:0] prot_vec;
  logic                         any_hit;
  logic [IDX_W-1:0]             win_idx;
  logic [BASE_W-1:0]            win_pa;
  logic [ATTR_W-1:0]            win_attr;
  logic [PROT_W-1:0]            win_prot;
  logic                         accept;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    bat_entry u_ent (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_vec[e]),
      .wdata (wdata),
      .ea    (lk_ea),
      .user  (lk_user),
      .hit   (hit_vec[e]),
      .pa_hi (pa_vec[e]),
      .attr  (attr_vec[e]),
      .prot  (prot_vec[e])
    );
  end

  bat_pick #(.N_ENT(N_ENT)) u_pick (
    .hit_vec  (hit_vec),
    .pa_vec   (pa_vec),
    .attr_vec (attr_vec),
    .prot_vec (prot_vec),
    .any_hit  (any_hit),
    .win_idx  (win_idx),
    .win_pa   (win_pa),
    .win_attr (win_attr),
    .win_prot (win_prot)
  );

  assign lk_ready = !rs_valid || rs_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_pa    <= '0;
      rs_idx   <= '0;
      rs_attr  <= '0;
      rs_prot  <= '0;
    end else if (accept) begin
      rs_valid <= 1'b1;
      rs_hit   <= any_hit;
      rs_pa    <= any_hit ? {win_pa, lk_ea[LOW_BITS-1:0]} : '0;
      rs_idx   <= win_idx;
      rs_attr  <= win_attr;
      rs_prot  <= win_prot;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
  import bat_xl_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int N_SIDE = 2,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int SIDE_W = (N_SIDE > 1) ? $clog2(N_SIDE) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [SIDE_W-1:0]              wr_side,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [BASE_W-1:0]              wr_vbase,
  input  logic [MASK_W-1:0]              wr_len_mask,
  input  logic                           wr_sup_ok,
  input  logic                           wr_usr_ok,
  input  logic [BASE_W-1:0]              wr_pbase,
  input  logic [ATTR_W-1:0]              wr_attr,
  input  logic [PROT_W-1:0]              wr_prot,
  input  logic [N_SIDE-1:0]              lk_valid,
  output logic [N_SIDE-1:0]              lk_ready,
  input  logic [N_SIDE-1:0][AW-1:0]      lk_ea,
  input  logic [N_SIDE-1:0]              lk_user,
  output logic [N_SIDE-1:0]              rs_valid,
  input  logic [N_SIDE-1:0]              rs_ready,
  output logic [N_SIDE-1:0]              rs_hit,
  output logic [N_SIDE-1:0][AW-1:0]      rs_pa,
  output logic [N_SIDE-1:0][IDX_W-1:0]   rs_idx,
  output logic [N_SIDE-1:0][ATTR_W-1:0]  rs_attr,
  output logic [N_SIDE-1:0][PROT_W-1:0]  rs_prot
);
  bat_ent_t wdata;

  assign wdata = '{vbase: wr_vbase, len_mask: wr_len_mask, sup_ok: wr_sup_ok,
                   usr_ok: wr_usr_ok, pbase: wr_pbase, attr: wr_attr, prot: wr_prot};

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    logic [N_ENT-1:0] we_vec;
    for (genvar e = 0; e < N_ENT; e++) begin : g_we
      assign we_vec[e] = wr_en && (wr_side == SIDE_W'(s)) && (wr_idx == IDX_W'(e));
    end

    bat_side #(.N_ENT(N_ENT)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_vec   (we_vec),
      .wdata    (wdata),
      .lk_valid (lk_valid[s]),
      .lk_ready (lk_ready[s]),
      .lk_ea    (lk_ea[s]),
      .lk_user  (lk_user[s]),
      .rs_valid (rs_valid[s]),
      .rs_ready (rs_ready[s]),
      .rs_hit   (rs_hit[s]),
      .rs_pa    (rs_pa[s]),
      .rs_idx   (rs_idx[s]),
      .rs_attr  (rs_attr[s]),
      .rs_prot  (rs_prot[s])
    );
  end
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_xl_pkg::*;
#(
  parameter int N_ENT = 4,
  parameter int N_SIDE = 2,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [N_SIDE-1:0]             lk_valid,
  input logic [N_SIDE-1:0]             lk_ready,
  input logic [N_SIDE-1:0]             rs_valid,
  input logic [N_SIDE-1:0]             rs_ready,
  input logic [N_SIDE-1:0]             rs_hit,
  input logic [N_SIDE-1:0][AW-1:0]     rs_pa,
  input logic [N_SIDE-1:0][IDX_W-1:0]  rs_idx,
  input logic [N_SIDE-1:0][ATTR_W-1:0] rs_attr,
  input logic [N_SIDE-1:0][PROT_W-1:0] rs_prot
);
  for (genvar s = 0; s < N_SIDE; s++) begin : g_chk
    assert_reset_empty_R1: assert property (@(posedge clk)
      !rst_n |=> !rs_valid[s]);

    assert_accept_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid[s] && lk_ready[s]) |=> rs_valid[s]);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid[s] && !rs_ready[s]) |=>
        (rs_valid[s] && $stable(rs_hit[s]) && $stable(rs_pa[s]) && $stable(rs_idx[s])
         && $stable(rs_attr[s]) && $stable(rs_prot[s])));

    assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid[s] && !rs_ready[s]) |-> !lk_ready[s]);

    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_valid[s] && !rs_hit[s]) |->
        (rs_pa[s] == '0 && rs_idx[s] == '0 && rs_attr[s] == '0 && rs_prot[s] == '0));
  end
endmodule

bind bat_xlate_unit bat_xlate_chk #(.N_ENT(N_ENT), .N_SIDE(N_SIDE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_ready (lk_ready),
  .rs_valid (rs_valid),
  .rs_ready (rs_ready),
  .rs_hit   (rs_hit),
  .rs_pa    (rs_pa),
  .rs_idx   (rs_idx),
  .rs_attr  (rs_attr),
  .rs_prot  (rs_prot)
);

// File: tb/tb_bat_xlate_unit.sv
module tb_bat_xlate_unit;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [0:0]        wr_side = '0;
  logic [1:0]        wr_idx = '0;
  logic [14:0]       wr_vbase = '0;
  logic [10:0]       wr_len_mask = '0;
  logic              wr_sup_ok = 1'b0;
  logic              wr_usr_ok = 1'b0;
  logic [14:0]       wr_pbase = '0;
  logic [3:0]        wr_attr = '0;
  logic [1:0]        wr_prot = '0;
  logic [1:0]        lk_valid = '0;
  logic [1:0]        lk_ready;
  logic [1:0][31:0]  lk_ea = '0;
  logic [1:0]        lk_user = '0;
  logic [1:0]        rs_valid;
  logic [1:0]        rs_ready = 2'b11;
  logic [1:0]        rs_hit;
  logic [1:0][31:0]  rs_pa;
  logic [1:0][1:0]   rs_idx;
  logic [1:0][3:0]   rs_attr;
  logic [1:0][1:0]   rs_prot;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bat_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side), .wr_idx(wr_idx),
    .wr_vbase(wr_vbase), .wr_len_mask(wr_len_mask), .wr_sup_ok(wr_sup_ok),
    .wr_usr_ok(wr_usr_ok), .wr_pbase(wr_pbase), .wr_attr(wr_attr), .wr_prot(wr_prot),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_ea(lk_ea), .lk_user(lk_user),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_pa(rs_pa),
    .rs_idx(rs_idx), .rs_attr(rs_attr), .rs_prot(rs_prot)
  );

  // ---------------- behavioural reference model ----------------
  int m_vb[2][4], m_mask[2][4], m_pb[2][4], m_at[2][4], m_pr[2][4];
  bit m_sv[2][4], m_uv[2][4];
  bit m_rv[2], m_hit[2];
  logic [31:0] m_pa[2];
  int m_idx[2], m_attr[2], m_prot[2];

  function automatic void model_look(input int s, input logic [31:0] ea, input bit u,
      output bit h, output logic [31:0] pa, output int idx, output int at, output int pr);
    longint ea64, base, pb64;
    int sh;
    h = 0; pa = '0; idx = 0; at = 0; pr = 0;
    ea64 = longint'(ea);
    for (int i = 0; i < 4; i++) begin
      if (!h && (u ? m_uv[s][i] : m_sv[s][i])) begin
        sh   = 17 + $countones(m_mask[s][i]);
        base = longint'(m_vb[s][i]) << 17;
        pb64 = longint'(m_pb[s][i]) << 17;
        if ((ea64 >> sh) == (base >> sh)) begin
          h   = 1;
          pa  = 32'(((pb64 >> sh) << sh) | (ea64 & ((64'd1 << sh) - 1)));
          idx = i; at = m_at[s][i]; pr = m_pr[s][i];
        end
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_rv[s] = 0; m_hit[s] = 0; m_pa[s] = '0; m_idx[s] = 0; m_attr[s] = 0; m_prot[s] = 0;
        for (int i = 0; i < 4; i++) begin
          m_vb[s][i] = 0; m_mask[s][i] = 0; m_pb[s][i] = 0; m_at[s][i] = 0;
          m_pr[s][i] = 0; m_sv[s][i] = 0; m_uv[s][i] = 0;
        end
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (lk_valid[s] && (!m_rv[s] || rs_ready[s])) begin
          m_rv[s] = 1;
          model_look(s, lk_ea[s], lk_user[s], m_hit[s], m_pa[s], m_idx[s], m_attr[s], m_prot[s]);
        end else if (rs_ready[s]) begin
          m_rv[s] = 0;
        end
      end
      if (wr_en) begin
        m_vb[wr_side][wr_idx] = int'(wr_vbase); m_mask[wr_side][wr_idx] = int'(wr_len_mask);
        m_pb[wr_side][wr_idx] = int'(wr_pbase); m_at[wr_side][wr_idx] = int'(wr_attr);
        m_pr[wr_side][wr_idx] = int'(wr_prot); m_sv[wr_side][wr_idx] = wr_sup_ok;
        m_uv[wr_side][wr_idx] = wr_usr_ok;
      end
    end
  end

  // Every-cycle comparison, a quarter period after the falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      for (int s = 0; s < 2; s++) begin
        checks++;
        if (lk_ready[s] !== (!m_rv[s] || rs_ready[s]) || rs_valid[s] !== m_rv[s]) begin
          errors++;
          $display("FAIL R7 side %0d: ready/valid actual %b/%b expected %b/%b", s,
                   lk_ready[s], rs_valid[s], (!m_rv[s] || rs_ready[s]), m_rv[s]);
        end
        if (m_rv[s]) begin
          checks++;
          if (rs_hit[s] !== m_hit[s] || rs_pa[s] !== m_pa[s] || int'(rs_idx[s]) != m_idx[s]
              || int'(rs_attr[s]) != m_attr[s] || int'(rs_prot[s]) != m_prot[s]) begin
            errors++;
            $display("FAIL R3 side %0d model: hit/pa/idx actual %b/%h/%0d expected %b/%h/%0d",
                     s, rs_hit[s], rs_pa[s], rs_idx[s], m_hit[s], m_pa[s], m_idx[s]);
          end
        end
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int side, input int idx, input logic [31:0] vaddr, input int mask,
                    input bit sup, input bit usr, input logic [31:0] paddr, input int at, input int pr);
    @(negedge clk);
    wr_en = 1; wr_side = 1'(side); wr_idx = 2'(idx);
    wr_vbase = vaddr[31:17]; wr_len_mask = 11'(mask); wr_sup_ok = sup; wr_usr_ok = usr;
    wr_pbase = paddr[31:17]; wr_attr = 4'(at); wr_prot = 2'(pr);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input int s, input logic [31:0] ea, input bit u, input bit ehit,
                      input logic [31:0] epa, input int eidx, input string tag);
    @(negedge clk);
    lk_valid[s] = 1; lk_ea[s] = ea; lk_user[s] = u;
    @(posedge clk);
    @(negedge clk);
    lk_valid[s] = 0;
    #1;
    check({tag, " hit"}, 64'(rs_hit[s]), 64'(ehit));
    check({tag, " pa"},  64'(rs_pa[s]),  64'(epa));
    check({tag, " idx"}, 64'(rs_idx[s]), 64'(eidx));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rs_valid after reset", 64'(rs_valid), 64'd0);
    check("R1 lk_ready after reset", 64'(lk_ready), 64'd3);
    @(negedge clk);
    rst_n = 1;
    look(0, 32'h1001_2345, 0, 0, 32'h0, 0, "R1 empty side0");
    check("R10 miss attr", 64'(rs_attr[0]), 64'd0);

    // side 0 entries
    wr(0, 0, 32'h1000_0000, 0,     1, 0, 32'h2000_0000, 1, 2); // 128 KB, supervisor only
    wr(0, 1, 32'h3000_0000, 'h7FF, 1, 0, 32'h5000_0000, 2, 3); // 256 MB, supervisor only
    wr(0, 2, 32'h1000_0000, 'h007, 0, 1, 32'h7000_0000, 5, 1); // 1 MB, user only
    wr(0, 3, 32'h1000_0000, 0,     1, 1, 32'h0000_0000, 7, 0); // 128 KB, both

    look(0, 32'h1001_2345, 0, 1, 32'h2001_2345, 0, "R5 sup overlap");
    look(0, 32'h1001_FFFF, 0, 1, 32'h2001_FFFF, 0, "R2 128KB top edge");
    look(0, 32'h1002_0000, 0, 0, 32'h0,         0, "R2 128KB past edge");
    look(0, 32'h3ABC_DEF0, 0, 1, 32'h5ABC_DEF0, 1, "R3 256MB pa");
    look(0, 32'h3FFF_FFFF, 0, 1, 32'h5FFF_FFFF, 1, "R2 256MB top edge");
    look(0, 32'h4000_0000, 0, 0, 32'h0,         0, "R10 256MB past edge");
    look(0, 32'h3ABC_DEF0, 1, 0, 32'h0,         0, "R4 user on sup entry");
    look(0, 32'h1001_2345, 1, 1, 32'h7001_2345, 2, "R5 user overlap");
    look(0, 32'h100A_BCDE, 1, 1, 32'h700A_BCDE, 2, "R3 1MB pa");
    look(0, 32'h100A_BCDE, 0, 0, 32'h0,         0, "R4 sup on user entry");

    // R6: data side untouched by side-0 writes
    look(1, 32'h1001_2345, 0, 0, 32'h0, 0, "R6 side1 still empty");
    wr(1, 0, 32'h1000_0000, 'h00F, 1, 1, 32'h0020_0000, 3, 1); // 2 MB
    look(1, 32'h101F_FFFC, 0, 1, 32'h003F_FFFC, 0, "R6 side1 own entry");
    look(0, 32'h101F_FFFC, 0, 0, 32'h0,         0, "R6 side0 unaffected");

    // R9: write that disables entry 0 lands with a lookup at the same edge
    @(negedge clk);
    wr_en = 1; wr_side = 0; wr_idx = 0; wr_sup_ok = 0; wr_usr_ok = 0;
    wr_vbase = 15'h800; wr_len_mask = 0; wr_pbase = 15'h1000; wr_attr = 1; wr_prot = 2;
    lk_valid[0] = 1; lk_ea[0] = 32'h1001_2345; lk_user[0] = 0;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; lk_valid[0] = 0;
    #1;
    check("R9 old contents idx", 64'(rs_idx[0]), 64'd0);
    check("R9 old contents pa",  64'(rs_pa[0]),  64'h2001_2345);
    look(0, 32'h1001_2345, 0, 1, 32'h0001_2345, 3, "R9 new contents");

    // R8: stalled result holds while a second request waits
    @(negedge clk);
    rs_ready[0] = 0; lk_valid[0] = 1; lk_ea[0] = 32'h3000_0010; lk_user[0] = 0;
    @(posedge clk);
    @(negedge clk);
    lk_ea[0] = 32'h1001_0000; lk_user[0] = 1;
    #1;
    check("R7 blocked while full", 64'(lk_ready[0]), 64'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R8 held pa", 64'(rs_pa[0]), 64'h5000_0010);
    check("R8 held idx", 64'(rs_idx[0]), 64'd1);
    rs_ready[0] = 1;
    #1;
    check("R7 ready on drain", 64'(lk_ready[0]), 64'd1);
    @(posedge clk);
    @(negedge clk);
    lk_valid[0] = 0;
    #1;
    check("R7 second result pa", 64'(rs_pa[0]), 64'h7001_0000);
    check("R7 second result idx", 64'(rs_idx[0]), 64'd2);
    @(negedge clk);
    #1;
    check("R7 drained", 64'(rs_valid[0]), 64'd0);

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule